// File: doc/BRIEF.md
# Scalable Single-Input-Change Pattern Counter

This block feeds a set of parallel scan chains with Johnson-style codewords without building a Johnson register as long as the scan chains. It keeps a small fill count and a fill polarity. At the start of each shift window it loads the count into a down-counter. On each enabled test clock of the window it pushes one bit into a short shift register whose stages drive the chains. The bit equals the fill polarity while the down-counter is non-zero and its complement once the counter reaches zero. Each stage of the shift register is the stage before it delayed by one shift, so every chain receives a shifted, and therefore distinct, copy of the same single-input-change stream.

The fill count advances by one each time scan enable falls, which closes a shift window. When the count passes `SCAN_LEN-1` it wraps to zero and the polarity flips. Over `2*SCAN_LEN` windows the serial stream therefore follows all states of a `SCAN_LEN`-bit Johnson counter. For window p, stream bit t equals bit t of that counter after p steps from all zeros. The state costs about `2*log2(SCAN_LEN)+NUM_CHAINS` flip-flops.

Scan enable is sampled on the block clock and its falling edge is found from a registered copy. Between windows, scan enable must stay low for at least two clock cycles. The first low cycle advances the count and the second loads the new count into the down-counter.

Top module: `sic_scalable_counter`

## Requirements
- R1: A synchronous active-high reset clears all chain outputs, the fill count and the down-counter to 0 and sets the fill polarity to 1. The first window after reset therefore emits only 0 bits.
- R2: Within a window that starts with count c and polarity P, the first c shifted bits equal P and the remaining `SCAN_LEN-c` bits equal the complement of P.
- R3: The fill count rises by exactly one on each falling edge of scan enable, however long scan enable then stays low (2 cycles or more).
- R4: When a falling edge finds the count at `SCAN_LEN-1`, the count becomes 0 and the polarity inverts. The stream therefore repeats after `2*SCAN_LEN` windows.
- R5: On each clock with scan enable and test-clock enable both high, `chain_o[i+1]` takes the old `chain_o[i]` and `chain_o[0]` takes the new fill bit. Bit 0 carries the newest bit.
- R6: When test-clock enable is low, `chain_o` and the down-counter hold, including in the middle of a window. A paused window emits the same stream as an unpaused one.
- R7: While scan enable is low, the down-counter loads the fill count and `chain_o` does not change. While scan enable is high, each enabled test clock decrements the down-counter once, and the counter stays at zero once it reaches zero.
- R8: Across windows, the serial stream at `chain_o[0]` equals the output sequence of a `SCAN_LEN`-bit Johnson counter, read bit 0 first, one state per window, starting from all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| tck_en | input | 1 | Test-clock enable; a shift happens only on cycles where it is high |
| scan_en | input | 1 | Scan enable; high during a shift window, its falling edge advances the fill count |
| chain_o | output | NUM_CHAINS | Shift register stages, one per scan chain; bit 0 is the newest bit |

## Verification
The bench runs `2*SCAN_LEN+3` windows back to back. This covers every fill count under both polarities and proves the wrap, because windows 128 to 130 must repeat windows 0 to 2. The low gap between windows varies between 2 and 4 cycles, which separates an advance tied to the falling edge from one that counts low cycles. Some windows carry a three-cycle pause of test-clock enable in the middle; their stream must match the stream an unpaused window would give, and `chain_o` must not move during the pause. On every shift the upper stages are compared with the previous lower stages, which tells a true shift register apart from stages that are loaded independently.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // Width of a counter that must hold values 0 .. len-1.
  function automatic int sic_cnt_w(input int len);
    return (len < 2) ? 1 : $clog2(len);
  endfunction
endpackage

// File: rtl/sic_fill_adder.sv
module sic_fill_adder
  import sic_pkg::*;
#(
  parameter int SCAN_LEN = 64,
  localparam int CNT_W = sic_cnt_w(SCAN_LEN)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  output logic [CNT_W-1:0] fill_cnt,
  output logic             fill_pol
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(SCAN_LEN - 1);

  logic se_q;
  logic se_fall;

  assign se_fall = se_q & ~scan_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      se_q     <= 1'b0;
      fill_cnt <= '0;
      fill_pol <= 1'b1;
    end else begin
      se_q <= scan_en;
      if (se_fall) begin
        if (fill_cnt == LIMIT) begin
          fill_cnt <= '0;
          fill_pol <= ~fill_pol;
        end else begin
          fill_cnt <= fill_cnt + 1'b1;
        end
      end
    end
  end

  // R3: one step per falling edge, polarity kept
  a_r3_step: assert property (@(posedge clk) disable iff (rst)
    (se_fall && fill_cnt != LIMIT) |=> (fill_cnt == $past(fill_cnt) + 1'b1) && (fill_pol == $past(fill_pol)));
  // R4: wrap to zero and polarity flip
  a_r4_wrap: assert property (@(posedge clk) disable iff (rst)
    (se_fall && fill_cnt == LIMIT) |=> (fill_cnt == '0) && (fill_pol != $past(fill_pol)));
  // R3: count never moves without a falling edge
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !se_fall |=> $stable(fill_cnt) && $stable(fill_pol));
endmodule

// File: rtl/sic_down_counter.sv
module sic_down_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             scan_en,
  input  logic             tck_en,
  input  logic [CNT_W-1:0] load_val,
  output logic             nonzero
);
  logic [CNT_W-1:0] cnt;

  assign nonzero = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (!scan_en) begin
      cnt <= load_val;
    end else if (tck_en && nonzero) begin
      cnt <= cnt - 1'b1;
    end
  end

  // R7: load while scan enable is low
  a_r7_load: assert property (@(posedge clk) disable iff (rst)
    !scan_en |=> cnt == $past(load_val));
  // R7: decrement per enabled test clock
  a_r7_dec: assert property (@(posedge clk) disable iff (rst)
    (scan_en && tck_en && cnt != '0) |=> cnt == $past(cnt) - 1'b1);
  // R7: zero is sticky inside a window
  a_r7_zero: assert property (@(posedge clk) disable iff (rst)
    (scan_en && cnt == '0) |=> cnt == '0);
  // R6: hold when test clock is disabled
  a_r6_cnt_hold: assert property (@(posedge clk) disable iff (rst)
    (scan_en && !tck_en) |=> $stable(cnt));
endmodule

// File: rtl/sic_shift_reg.sv
module sic_shift_reg #(
  parameter int NUM_CHAINS = 10
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  shift_en,
  input  logic                  din,
  output logic [NUM_CHAINS-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (shift_en) begin
      q <= {q[NUM_CHAINS-2:0], din};
    end
  end

  // R5: each stage takes its lower neighbour
  a_r5_shift: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> q[NUM_CHAINS-1:1] == $past(q[NUM_CHAINS-2:0]));
  // R6: no shift, no change
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(q));
endmodule

// File: rtl/sic_scalable_counter.sv
module sic_scalable_counter
  import sic_pkg::*;
#(
  parameter int NUM_CHAINS = 10,
  parameter int SCAN_LEN   = 64
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  tck_en,
  input  logic                  scan_en,
  output logic [NUM_CHAINS-1:0] chain_o
);
  localparam int CNT_W = sic_cnt_w(SCAN_LEN);

  logic [CNT_W-1:0] fill_cnt;
  logic             fill_pol;
  logic             cnt_nz;
  logic             fill_bit;
  logic             shift_en;

  assign shift_en = scan_en & tck_en;
  assign fill_bit = cnt_nz ? fill_pol : ~fill_pol;

  sic_fill_adder #(.SCAN_LEN(SCAN_LEN)) u_adder (
    .clk(clk), .rst(rst), .scan_en(scan_en),
    .fill_cnt(fill_cnt), .fill_pol(fill_pol)
  );

  sic_down_counter #(.CNT_W(CNT_W)) u_down (
    .clk(clk), .rst(rst), .scan_en(scan_en), .tck_en(tck_en),
    .load_val(fill_cnt), .nonzero(cnt_nz)
  );

  sic_shift_reg #(.NUM_CHAINS(NUM_CHAINS)) u_sreg (
    .clk(clk), .rst(rst), .shift_en(shift_en), .din(fill_bit), .q(chain_o)
  );

  // R2: fill value while count remains
  a_r2_fill: assert property (@(posedge clk) disable iff (rst)
    (shift_en && cnt_nz) |=> chain_o[0] == $past(fill_pol));
  // R2: complement once the count is exhausted
  a_r2_tail: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !cnt_nz) |=> chain_o[0] != $past(fill_pol));
endmodule

// File: tb/tb_sic_scalable_counter.sv
`timescale 1ns/1ps
module tb_sic_scalable_counter;
  localparam int M = 10;
  localparam int L = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tck_en = 1'b0;
  logic scan_en = 1'b0;
  logic [M-1:0] chain_o;

  int checks = 0;
  int bad = 0;
  logic exp_q[$];
  logic [L-1:0] ref_j = '0;
  logic shift_seen = 1'b0;
  logic [M-1:0] prev;
  bit done = 1'b0;

  always #2 clk = ~clk;

  sic_scalable_counter #(.NUM_CHAINS(M), .SCAN_LEN(L)) dut (
    .clk(clk), .rst(rst), .tck_en(tck_en), .scan_en(scan_en), .chain_o(chain_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) shift_seen <= scan_en && tck_en && !rst;

  // Monitor: pops expected stream bits as shifts happen
  always @(negedge clk) begin
    if (!rst) begin
      if (shift_seen) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R8 unexpected shift", 1, 0);
        end else begin
          logic e;
          e = exp_q.pop_front();
          check(chain_o[0] == e, "R2/R8 serial bit", int'(chain_o[0]), int'(e));
        end
        check(chain_o[M-1:1] == prev[M-2:0], "R5 stage shift",
              int'(chain_o[M-1:1]), int'(prev[M-2:0]));
      end else begin
        check(chain_o == prev, "R6/R7 hold without shift", int'(chain_o), int'(prev));
      end
    end
    prev = chain_o;
  end

  // Driver: pushes the reference Johnson state, then runs one window
  task automatic run_window(input int gap, input bit pause);
    for (int t = 0; t < L; t++) exp_q.push_back(ref_j[t]);
    ref_j = {ref_j[L-2:0], ~ref_j[L-1]};
    for (int t = 0; t < L; t++) begin
      if (pause && t == L/2) begin
        scan_en = 1'b1; tck_en = 1'b0;
        repeat (3) begin @(posedge clk); #1; end
      end
      scan_en = 1'b1; tck_en = 1'b1;
      @(posedge clk); #1;
    end
    scan_en = 1'b0; tck_en = (gap % 2 == 1);
    repeat (gap) begin @(posedge clk); #1; end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(chain_o == '0, "R1 reset outputs", int'(chain_o), 0);
    @(posedge clk); #1;
    // R1 R3 R4 R6 R8: full cycle of 2L windows plus three to see the repeat
    for (int p = 0; p < 2*L + 3; p++) begin
      run_window(2 + (p % 3), (p % 7) == 3);
    end
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, "R8 stream length", exp_q.size(), 0);
    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
    if (!done) check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule